// File: doc/BRIEF.md
# Serial Port Interrupt Flag and Enable Register

This block holds the interrupt status byte of an asynchronous serial port. Event strobes and levels from the receiver, the transmitter, the clear-to-send change detector and the error detectors are collected into one 8-bit flag register. Software reads the flags on `flags_o`. Each flag obeys its own clearing rule. Five flags are cleared by writing a one to their bit. The receive-complete flag drops on a read of the data register or when the receiver is disabled. The transmit-complete flag also drops on a write to the data register. The data-register-empty bit is a live copy of its input level.

Each sticky flag is a two-state machine. `FLAG_IDLE` moves to `FLAG_PENDING` on the *arm* transition, when the set event is present. `FLAG_PENDING` goes back to `FLAG_IDLE` on the *release* transition, when a clear request is present and no set event is. In every other case the state holds. A separate 8-bit enable register has its own set and clear write strobes. The single interrupt request is high whenever a flag and its enable bit are both one.

Top module: `sif_irq_flags`

## Requirements
- R1: After reset, or on a later reset, the flag byte reads 0x00 (with `tx_empty_i` low), the enable byte reads 0x00 and `irq_o` is low.
- R2: Bit 7 (error) becomes one in the cycle after any bit of `err_strobe_i` is high. It clears only on a flag write with bit 7 of the data set to one.
- R3: Bit 5 (break received) is set by `break_i` only while `autobaud_en_i` is high. It clears on a flag write with bit 5 set to one.
- R4: Bit 4 is set by a rising or a falling edge of `cts_i`. The first clock after reset only records the level and sets nothing. The bit clears on a flag write with bit 4 set to one.
- R5: Bit 3 (receive start) is set by `start_i` only while `sof_en_i` is high. It clears on a flag write with bit 3 set to one.
- R6: Bit 2 (receive complete) is set by `rx_done_i` while `rx_en_i` is high. It clears on `data_rd_i` or whenever `rx_en_i` is low. Flag writes have no effect on it.
- R7: Bit 1 (transmit complete) is set by `tx_done_i`. It clears on `data_wr_i` or on a flag write with bit 1 set to one.
- R8: Bit 0 always equals `tx_empty_i`, and flag writes do not change it. Bit 6 always reads zero.
- R9: A zero written to any flag bit leaves that flag unchanged.
- R10: When a set event and a clear request reach the same sticky flag in one cycle, the flag ends up set.
- R11: `en_set_i` ORs `reg_wdata_i` into the enable byte, and `en_clr_i` clears the bits that are one in `reg_wdata_i`. If both strobes are high in the same cycle, the set wins.
- R12: `irq_o` is high exactly when some bit is one in both `flags_o` and `irq_en_o`. It follows changes of either one without further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Write strobe to the flag register |
| en_set_i | input | 1 | Write strobe that sets enable bits |
| en_clr_i | input | 1 | Write strobe that clears enable bits |
| reg_wdata_i | input | 8 | Write data shared by the three write strobes |
| data_rd_i | input | 1 | Read of the receive data register |
| data_wr_i | input | 1 | Write of the transmit data register |
| err_strobe_i | input | NUM_ERR | Error pulses: collision, sync, overflow, framing, parity |
| break_i | input | 1 | Break character received |
| autobaud_en_i | input | 1 | Auto-baud framing selected |
| cts_i | input | 1 | Clear-to-send level, already synchronised |
| start_i | input | 1 | Start condition seen on the receive line |
| sof_en_i | input | 1 | Start-of-frame detection enabled |
| rx_done_i | input | 1 | Receive word placed in the data register |
| rx_en_i | input | 1 | Receiver enabled |
| tx_done_i | input | 1 | Transmission finished |
| tx_empty_i | input | 1 | Transmit data register empty |
| flags_o | output | 8 | Flag register read value |
| irq_en_o | output | 8 | Enable register read value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default of five error sources in the 8-bit register. At that size every error input can be pulsed on its own or together with the others, which reaches every arm and release transition of each flag machine. The set-against-clear collision is driven on both the error flag and the receive-complete flag. The gating inputs (auto-baud, start-of-frame and receiver enable) are each checked low as well as high. The change detector is checked with its input already high when reset ends, to confirm that no edge is reported in the first cycle.

// File: rtl/sif_pkg.sv
package sif_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_DRE   = 0;
    localparam int BIT_TXC   = 1;
    localparam int BIT_RXC   = 2;
    localparam int BIT_RXS   = 3;
    localparam int BIT_CTSIC = 4;
    localparam int BIT_RXBRK = 5;
    localparam int BIT_RSVD  = 6;
    localparam int BIT_ERROR = 7;
    // bits held by a sticky flag machine
    localparam logic [REG_W-1:0] STICKY_MASK = 8'b1011_1110;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;
endpackage

// File: rtl/sif_flag_cell.sv
module sif_flag_cell
    import sif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (set_i) state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_i && !set_i) state_d = FLAG_IDLE;
            default:      state_d = FLAG_IDLE;
        endcase
    end

    always_comb flag_o = (state_q == FLAG_PENDING);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/sif_cts_edge.sv
module sif_cts_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_i,
    output logic change_o
);
    logic cts_q;
    logic primed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_q    <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            cts_q    <= cts_i;
            primed_q <= 1'b1;
        end
    end

    always_comb change_o = primed_q && (cts_i != cts_q);

    assert_edge_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (change_o == (cts_i != $past(cts_i))));
endmodule

// File: rtl/sif_irq_mask.sv
module sif_irq_mask #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_set_i,
    input  logic         en_clr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] flags_i,
    output logic [W-1:0] en_o,
    output logic         irq_o
);
    logic [W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= '0;
        else if (en_set_i) en_q <= en_q | wdata_i;
        else if (en_clr_i) en_q <= en_q & ~wdata_i;
    end

    always_comb begin
        en_o  = en_q;
        irq_o = |(flags_i & en_q);
    end

    assert_en_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));
    assert_en_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr_i && !en_set_i) |=> ((en_o & $past(wdata_i)) == '0));
endmodule

// File: rtl/sif_irq_flags.sv
module sif_irq_flags
    import sif_pkg::*;
#(
    parameter int NUM_ERR = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_i,
    input  logic               en_set_i,
    input  logic               en_clr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    input  logic               data_rd_i,
    input  logic               data_wr_i,
    input  logic [NUM_ERR-1:0] err_strobe_i,
    input  logic               break_i,
    input  logic               autobaud_en_i,
    input  logic               cts_i,
    input  logic               start_i,
    input  logic               sof_en_i,
    input  logic               rx_done_i,
    input  logic               rx_en_i,
    input  logic               tx_done_i,
    input  logic               tx_empty_i,
    output logic [REG_W-1:0]   flags_o,
    output logic [REG_W-1:0]   irq_en_o,
    output logic               irq_o
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] flag_bits;
    logic             cts_change;

    sif_cts_edge u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .cts_i    (cts_i),
        .change_o (cts_change)
    );

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        set_vec[BIT_ERROR] = |err_strobe_i;
        clr_vec[BIT_ERROR] = reg_wr_i & reg_wdata_i[BIT_ERROR];
        set_vec[BIT_RXBRK] = break_i & autobaud_en_i;
        clr_vec[BIT_RXBRK] = reg_wr_i & reg_wdata_i[BIT_RXBRK];
        set_vec[BIT_CTSIC] = cts_change;
        clr_vec[BIT_CTSIC] = reg_wr_i & reg_wdata_i[BIT_CTSIC];
        set_vec[BIT_RXS]   = start_i & sof_en_i;
        clr_vec[BIT_RXS]   = reg_wr_i & reg_wdata_i[BIT_RXS];
        set_vec[BIT_RXC]   = rx_done_i & rx_en_i;
        clr_vec[BIT_RXC]   = data_rd_i | ~rx_en_i;
        set_vec[BIT_TXC]   = tx_done_i;
        clr_vec[BIT_TXC]   = data_wr_i | (reg_wr_i & reg_wdata_i[BIT_TXC]);
        // live bits: data-register-empty follows its level, reserved forced low
        set_vec[BIT_DRE]   = tx_empty_i;
        clr_vec[BIT_DRE]   = 1'b0;
        set_vec[BIT_RSVD]  = 1'b0;
        clr_vec[BIT_RSVD]  = 1'b1;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            sif_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[i]),
                .clr_i  (clr_vec[i]),
                .flag_o (flag_bits[i])
            );
        end else begin : g_live
            assign flag_bits[i] = set_vec[i] & ~clr_vec[i];
        end
    end

    always_comb flags_o = flag_bits;

    sif_irq_mask #(.W(REG_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set_i (en_set_i),
        .en_clr_i (en_clr_i),
        .wdata_i  (reg_wdata_i),
        .flags_i  (flag_bits),
        .en_o     (irq_en_o),
        .irq_o    (irq_o)
    );

    assert_rx_off_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !flags_o[BIT_RXC]);
    assert_err_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_strobe_i) |=> flags_o[BIT_ERROR]);
    assert_gated_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!autobaud_en_i && !flags_o[BIT_RXBRK]) |=> !flags_o[BIT_RXBRK]);
endmodule

// File: tb/tb_sif_irq_flags.sv
module tb_sif_irq_flags;
    localparam int CLK_P = 10;
    localparam int NV    = 33;

    localparam logic [10:0] C_ENC = 11'd1 << 0;
    localparam logic [10:0] C_ENS = 11'd1 << 1;
    localparam logic [10:0] C_WR  = 11'd1 << 2;
    localparam logic [10:0] C_TXE = 11'd1 << 3;
    localparam logic [10:0] C_DWR = 11'd1 << 4;
    localparam logic [10:0] C_TXD = 11'd1 << 5;
    localparam logic [10:0] C_RD  = 11'd1 << 6;
    localparam logic [10:0] C_RXD = 11'd1 << 7;
    localparam logic [10:0] C_STA = 11'd1 << 8;
    localparam logic [10:0] C_CTS = 11'd1 << 9;
    localparam logic [10:0] C_BRK = 11'd1 << 10;

    typedef struct packed {
        logic [4:0]  err;
        logic [10:0] ctl;
        logic [7:0]  wdata;
        logic [7:0]  exp_flags;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{5'b00001, 11'd0,         8'h00, 8'h80, 1'b0, 4'd2},  // R2 one source
        '{5'b00000, C_WR,          8'h7F, 8'h80, 1'b0, 4'd9},  // R9 zero leaves bit 7
        '{5'b00000, C_WR,          8'h80, 8'h00, 1'b0, 4'd2},  // R2 clear
        '{5'b10000, 11'd0,         8'h00, 8'h80, 1'b0, 4'd2},  // R2 other source
        '{5'b00100, C_WR,          8'h80, 8'h80, 1'b0, 4'd10}, // R10 set wins
        '{5'b00000, C_WR,          8'h80, 8'h00, 1'b0, 4'd2},
        '{5'b00000, C_BRK,         8'h00, 8'h20, 1'b0, 4'd3},  // R3
        '{5'b00000, C_WR,          8'h20, 8'h00, 1'b0, 4'd3},
        '{5'b00000, C_CTS,         8'h00, 8'h10, 1'b0, 4'd4},  // R4 rise
        '{5'b00000, C_CTS | C_WR,  8'h10, 8'h00, 1'b0, 4'd4},
        '{5'b00000, 11'd0,         8'h00, 8'h10, 1'b0, 4'd4},  // R4 fall
        '{5'b00000, C_WR,          8'h10, 8'h00, 1'b0, 4'd4},
        '{5'b00000, C_STA,         8'h00, 8'h08, 1'b0, 4'd5},  // R5
        '{5'b00000, C_WR,          8'h08, 8'h00, 1'b0, 4'd5},
        '{5'b00000, C_RXD,         8'h00, 8'h04, 1'b0, 4'd6},  // R6 set
        '{5'b00000, C_WR,          8'hFF, 8'h04, 1'b0, 4'd6},  // R6 write ignored
        '{5'b00000, C_RD,          8'h00, 8'h00, 1'b0, 4'd6},  // R6 read clears
        '{5'b00000, C_RXD | C_RD,  8'h00, 8'h04, 1'b0, 4'd10}, // R10 new data wins
        '{5'b00000, C_RD,          8'h00, 8'h00, 1'b0, 4'd6},
        '{5'b00000, C_TXD,         8'h00, 8'h02, 1'b0, 4'd7},  // R7
        '{5'b00000, C_DWR,         8'h00, 8'h00, 1'b0, 4'd7},  // R7 data write
        '{5'b00000, C_TXD,         8'h00, 8'h02, 1'b0, 4'd7},
        '{5'b00000, C_WR,          8'h02, 8'h00, 1'b0, 4'd7},  // R7 one written
        '{5'b00000, C_TXE,         8'h00, 8'h01, 1'b0, 4'd8},  // R8 live
        '{5'b00000, C_TXE | C_WR,  8'hFF, 8'h01, 1'b0, 4'd8},  // R8 writes ignored
        '{5'b00000, C_TXE | C_ENS, 8'h01, 8'h01, 1'b1, 4'd12}, // R12 request
        '{5'b00000, 11'd0,         8'h00, 8'h00, 1'b0, 4'd12}, // R12 drops with level
        '{5'b01000, C_ENS,         8'h80, 8'h80, 1'b1, 4'd12},
        '{5'b00000, C_ENC,         8'h80, 8'h80, 1'b0, 4'd11}, // R11 clear
        '{5'b00000, C_ENS | C_ENC, 8'h80, 8'h80, 1'b1, 4'd11}, // R11 set wins
        '{5'b00000, C_WR,          8'h80, 8'h00, 1'b0, 4'd2},
        '{5'b11111, C_TXD | C_BRK | C_STA, 8'h00, 8'hAA, 1'b1, 4'd2},
        '{5'b00000, C_WR,          8'hFF, 8'h00, 1'b0, 4'd9}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, en_set = 1'b0, en_clr = 1'b0;
    logic [7:0] wdata = '0;
    logic       data_rd = 1'b0, data_wr = 1'b0;
    logic [4:0] err = '0;
    logic       brk = 1'b0, autobaud = 1'b1, cts = 1'b0, start = 1'b0, sof = 1'b1;
    logic       rx_done = 1'b0, rx_en = 1'b1, tx_done = 1'b0, tx_empty = 1'b0;
    logic [7:0] flags, irq_en;
    logic       irq;
    int         n_checks = 0;
    int         n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    sif_irq_flags dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .en_set_i(en_set), .en_clr_i(en_clr),
        .reg_wdata_i(wdata), .data_rd_i(data_rd), .data_wr_i(data_wr), .err_strobe_i(err),
        .break_i(brk), .autobaud_en_i(autobaud), .cts_i(cts), .start_i(start),
        .sof_en_i(sof), .rx_done_i(rx_done), .rx_en_i(rx_en), .tx_done_i(tx_done),
        .tx_empty_i(tx_empty), .flags_o(flags), .irq_en_o(irq_en), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic strobes_off();
        reg_wr = 0; en_set = 0; en_clr = 0; data_rd = 0; data_wr = 0;
        err = '0; brk = 0; start = 0; rx_done = 0; tx_done = 0; wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        strobes_off();
        repeat (3) tick();
        rst_n = 1;
        tick();
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset flags", flags, 8'h00);
        chk("R1 reset enables", irq_en, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            err      = VECS[i].err;
            en_clr   = VECS[i].ctl[0];
            en_set   = VECS[i].ctl[1];
            reg_wr   = VECS[i].ctl[2];
            tx_empty = VECS[i].ctl[3];
            data_wr  = VECS[i].ctl[4];
            tx_done  = VECS[i].ctl[5];
            data_rd  = VECS[i].ctl[6];
            rx_done  = VECS[i].ctl[7];
            start    = VECS[i].ctl[8];
            cts      = VECS[i].ctl[9];
            brk      = VECS[i].ctl[10];
            wdata    = VECS[i].wdata;
            tick();
            chk($sformatf("R%0d vector %0d flags", VECS[i].req, i), flags, VECS[i].exp_flags);
            chk($sformatf("R%0d vector %0d irq", VECS[i].req, i), {7'd0, irq}, {7'd0, VECS[i].exp_irq});
        end
        strobes_off();
        tx_empty = 0;
        tick();

        // R3: break ignored without auto-baud
        autobaud = 0; brk = 1; tick(); strobes_off();
        chk("R3 break gated", flags, 8'h00);
        autobaud = 1;
        // R5: start ignored without start-of-frame detection
        sof = 0; start = 1; tick(); strobes_off();
        chk("R5 start gated", flags, 8'h00);
        sof = 1;
        // R6: receive word ignored with receiver off, then disable clears
        rx_en = 0; rx_done = 1; tick(); strobes_off();
        chk("R6 rx off gated", flags, 8'h00);
        rx_en = 1; rx_done = 1; tick(); strobes_off();
        chk("R6 rx word", flags, 8'h04);
        rx_en = 0; tick();
        chk("R6 disable clears", flags, 8'h00);
        rx_en = 1;

        // R1 / R4: later reset with cts already high reports no edge
        err = 5'b00010; tick(); strobes_off();
        chk("R2 pre-reset error", flags, 8'h80);
        cts = 1;
        do_reset();
        chk("R1 re-reset flags", flags, 8'h00);
        chk("R1 re-reset enables", irq_en, 8'h00);
        tick();
        chk("R4 no edge after reset", flags, 8'h00);
        chk("R1 irq low", {7'd0, irq}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule